// File: doc/BRIEF.md
# Synthesizer Serial Programming Front End with Fast-Lock Timer

This block takes the three-wire serial programming interface of a PLL frequency synthesizer (serial clock, serial data, load strobe) into the system clock domain. It assembles 24-bit control words and, when the load strobe rises, sends each word to one of three holding registers: the reference divider, the feedback (A/B) divider, or the function settings. The holding registers drive their decoded fields straight to the synthesizer core.

A fast-lock controller sits next to the registers. It picks which of two 3-bit charge-pump current codes drives the pump, based on a gain flag written with the feedback divider word. In the timed fast-lock mode the controller counts phase-detector cycles, which are given as one-cycle pulses on `pfd_tick`. When the programmed timeout has passed, it clears the gain flag by itself and falls back to the primary current. A chip-enable pin and a software power-down bit both put the block into power-down. In power-down the timer is held, but serial loads are still accepted.

Top module: `synth_prog_front`

## Requirements
- R1: The serial pins are synchronised to `clk`. On each rising edge of `ser_clk`, the bit on `ser_data` shifts into a 24-bit register, most significant bit first, so the last bit sent is DB0.
- R2: On a rising edge of `ser_le`, the held word goes to a register chosen by DB1:DB0. Code 00 selects the reference register, 01 selects the divider register and 10 selects the function register.
- R3: A word with DB1:DB0 = 11 changes no register and does not change the gain flag.
- R4: The reference register presents DB15:DB2 on `ref_div`.
- R5: The divider register presents DB7:DB2 on `a_div` and DB20:DB8 on `b_div`. DB21 is the gain flag written to the fast-lock controller.
- R6: The function register presents these fields: DB2 on `cnt_reset`, DB3 on `soft_pd`, DB6:DB4 on `mux_sel`, DB7 on `pd_polarity`, DB8 on `cp_hiz`, DB9 on `fl_enable`, DB10 on `fl_timed`, DB14:DB11 on `tmo_code`, DB17:DB15 on `cur_main`, DB20:DB18 on `cur_boost` and DB23:DB22 on `pre_sel`. DB21 is unused.
- R7: `cur_active` equals `cur_boost` while `gain` is 1 and `cur_main` while `gain` is 0. With `fl_enable` = 0 the gain flag changes only when a divider word is written, and `pfd_tick` has no effect on it.
- R8: With `fl_enable` = 1 and `fl_timed` = 0, a gain flag of 1 stays set through any number of `pfd_tick` pulses until a divider word writes it to 0.
- R9: With `fl_enable` = 1 and `fl_timed` = 1, writing the gain flag as 1 starts a timeout of 3 + 4·`tmo_code` ticks. The gain flag clears on exactly that tick and not before. A new write of 1 restarts the timeout.
- R10: `powered_down` is 1 whenever the synchronised `chip_en` is 0 or `soft_pd` is 1, whatever the value of the other. Serial loads are still accepted while powered down.
- R11: While `powered_down` is 1, the timeout counter is held at its full value and ticks are ignored. After power-down ends, the full timeout count starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector cycle |
| ref_div | output | 14 | Reference divide ratio |
| a_div | output | 6 | Swallow (A) count |
| b_div | output | 13 | Main (B) count |
| gain | output | 1 | Fast-lock gain flag |
| cnt_reset | output | 1 | Counter reset bit |
| soft_pd | output | 1 | Software power-down bit |
| mux_sel | output | 3 | Monitor output select |
| pd_polarity | output | 1 | Phase detector polarity |
| cp_hiz | output | 1 | Charge pump high-impedance request |
| fl_enable | output | 1 | Fast-lock enable |
| fl_timed | output | 1 | Fast-lock timed mode select |
| tmo_code | output | 4 | Timeout code |
| cur_main | output | 3 | Primary current code |
| cur_boost | output | 3 | Fast-lock current code |
| pre_sel | output | 2 | Prescaler code |
| cur_active | output | 3 | Current code in use now |
| powered_down | output | 1 | Power-down state |

## Verification
The bench sends words built bit by bit from the field positions. It uses distinctive patterns, so a reversed shift order or a field moved by one bit shows up as a wrong value. It checks that code 11 leaves every register as it was, which catches a decoder that treats the top code as an alias of another latch. For the timed mode it counts ticks up to one short of the timeout and then to the timeout itself, at both the shortest (3) and the longest (63) setting, which exposes off-by-one and wrong-scale counters. It also holds the block in power-down partway through a countdown to catch a timer that keeps running or resumes from where it stopped instead of reloading.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int WORD_W  = 24;
    localparam int REF_W   = 14;
    localparam int A_W     = 6;
    localparam int B_W     = 13;
    localparam int CUR_W   = 3;
    localparam int TC_W    = 4;
    localparam int CNT_W   = TC_W + 2;

    typedef enum logic [1:0] {
        DST_REF  = 2'b00,
        DST_DIV  = 2'b01,
        DST_FUNC = 2'b10,
        DST_NONE = 2'b11
    } dest_e;

    typedef struct packed {
        logic [1:0]       pre;
        logic [CUR_W-1:0] cur_b;
        logic [CUR_W-1:0] cur_m;
        logic [TC_W-1:0]  tc;
        logic             timed;
        logic             fl_en;
        logic             hiz;
        logic             pol;
        logic [2:0]       mux;
        logic             spd;
        logic             crst;
    } func_t;

    function automatic func_t unpack_func(input logic [WORD_W-1:0] w);
        func_t f;
        f.pre   = w[23:22];
        f.cur_b = w[20:18];
        f.cur_m = w[17:15];
        f.tc    = w[14:11];
        f.timed = w[10];
        f.fl_en = w[9];
        f.hiz   = w[8];
        f.pol   = w[7];
        f.mux   = w[6:4];
        f.spd   = w[3];
        f.crst  = w[2];
        return f;
    endfunction

    // timeout length in ticks: 3 + 4*code
    function automatic logic [CNT_W-1:0] tmo_len(input logic [TC_W-1:0] tc);
        return {tc, 2'b11};
    endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
    parameter int W = sp_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_i,
    input  logic         sdata_i,
    input  logic         le_i,
    output logic [W-1:0] word_o,
    output logic         load_o
);
    logic         sclk_p, le_p;
    logic [W-1:0] sh_q, word_q;
    logic         load_q;
    logic         sclk_rise, le_rise;

    assign sclk_rise = sclk_i && !sclk_p;
    assign le_rise   = le_i && !le_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= 1'b0;
            le_p   <= 1'b0;
            sh_q   <= '0;
            word_q <= '0;
            load_q <= 1'b0;
        end else begin
            sclk_p <= sclk_i;
            le_p   <= le_i;
            if (sclk_rise) sh_q <= {sh_q[W-2:0], sdata_i};
            load_q <= le_rise;
            if (le_rise) word_q <= sh_q;
        end
    end

    assign word_o = word_q;
    assign load_o = load_q;

    AST_LOAD_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
        load_q |-> $past(le_i)); // R2
endmodule

// File: rtl/sp_latches.sv
module sp_latches
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [REF_W-1:0]  ref_o,
    output logic [A_W-1:0]    a_o,
    output logic [B_W-1:0]    b_o,
    output logic              div_load_o,
    output logic              gain_wr_o,
    output func_t             fn_o
);
    dest_e          dst;
    logic [REF_W-1:0] ref_q;
    logic [A_W-1:0]   a_q;
    logic [B_W-1:0]   b_q;
    func_t            fn_q;

    assign dst = dest_e'(word_i[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            fn_q  <= '0;
        end else if (load_i) begin
            unique case (dst)
                DST_REF:  ref_q <= word_i[2 +: REF_W];
                DST_DIV: begin
                    a_q <= word_i[2 +: A_W];
                    b_q <= word_i[2 + A_W +: B_W];
                end
                DST_FUNC: fn_q  <= unpack_func(word_i);
                default:  ;
            endcase
        end
    end

    assign div_load_o = load_i && (dst == DST_DIV);
    assign gain_wr_o  = word_i[2 + A_W + B_W];
    assign ref_o      = ref_q;
    assign a_o        = a_q;
    assign b_o        = b_q;
    assign fn_o       = fn_q;

    AST_TOP_CODE_INERT: assert property (@(posedge clk) disable iff (rst)
        (load_i && word_i[1:0] == 2'b11) |=> ($stable(ref_q) && $stable(a_q) && $stable(b_q) && $stable(fn_q))); // R3
endmodule

// File: rtl/sp_fastlock.sv
module sp_fastlock
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             div_load_i,
    input  logic             gain_wr_i,
    input  logic             fl_en_i,
    input  logic             timed_i,
    input  logic [TC_W-1:0]  tc_i,
    input  logic [CUR_W-1:0] cur_m_i,
    input  logic [CUR_W-1:0] cur_b_i,
    input  logic             pd_i,
    input  logic             tick_i,
    output logic             gain_o,
    output logic [CUR_W-1:0] cur_o
);
    logic             gain_q;
    logic [CNT_W-1:0] cnt_q;
    logic             timer_on;

    assign timer_on = fl_en_i && timed_i && gain_q && tick_i && !pd_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (div_load_i) begin
                gain_q <= gain_wr_i;
                cnt_q  <= tmo_len(tc_i);
            end else if (timer_on) begin
                if (cnt_q <= CNT_W'(1)) gain_q <= 1'b0;
                else                    cnt_q  <= cnt_q - 1'b1;
            end
            if (pd_i) cnt_q <= tmo_len(tc_i);
        end
    end

    assign gain_o = gain_q;
    assign cur_o  = gain_q ? cur_b_i : cur_m_i;

    AST_GAIN_ONLY_BY_WRITE_OR_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (!div_load_i && !(tick_i && cnt_q == CNT_W'(1))) |=> $stable(gain_q)); // R8
    AST_AUTO_CLEAR_AT_LAST_TICK: assert property (@(posedge clk) disable iff (rst)
        ($fell(gain_q) && !$past(div_load_i)) |-> ($past(cnt_q) == CNT_W'(1) && $past(tick_i))); // R9
    AST_PD_RELOADS_TIMER: assert property (@(posedge clk) disable iff (rst)
        pd_i |=> (cnt_q == tmo_len($past(tc_i)))); // R11
endmodule

// File: rtl/synth_prog_front.sv
module synth_prog_front
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    input  logic              chip_en,
    input  logic              pfd_tick,
    output logic [REF_W-1:0]  ref_div,
    output logic [A_W-1:0]    a_div,
    output logic [B_W-1:0]    b_div,
    output logic              gain,
    output logic              cnt_reset,
    output logic              soft_pd,
    output logic [2:0]        mux_sel,
    output logic              pd_polarity,
    output logic              cp_hiz,
    output logic              fl_enable,
    output logic              fl_timed,
    output logic [TC_W-1:0]   tmo_code,
    output logic [CUR_W-1:0]  cur_main,
    output logic [CUR_W-1:0]  cur_boost,
    output logic [1:0]        pre_sel,
    output logic [CUR_W-1:0]  cur_active,
    output logic              powered_down
);
    logic [3:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic              load;
    logic              div_load, gain_wr;
    func_t             fn;
    logic              pd;

    sp_sync #(.W(4), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst),
        .d_i ({chip_en, ser_le, ser_data, ser_clk}),
        .q_o (pins_s)
    );

    sp_shifter #(.W(WORD_W)) u_shift (
        .clk (clk), .rst (rst),
        .sclk_i (pins_s[0]), .sdata_i (pins_s[1]), .le_i (pins_s[2]),
        .word_o (word), .load_o (load)
    );

    sp_latches u_lat (
        .clk (clk), .rst (rst),
        .load_i (load), .word_i (word),
        .ref_o (ref_div), .a_o (a_div), .b_o (b_div),
        .div_load_o (div_load), .gain_wr_o (gain_wr),
        .fn_o (fn)
    );

    assign pd = !pins_s[3] || fn.spd;

    sp_fastlock u_fl (
        .clk (clk), .rst (rst),
        .div_load_i (div_load), .gain_wr_i (gain_wr),
        .fl_en_i (fn.fl_en), .timed_i (fn.timed), .tc_i (fn.tc),
        .cur_m_i (fn.cur_m), .cur_b_i (fn.cur_b),
        .pd_i (pd), .tick_i (pfd_tick),
        .gain_o (gain), .cur_o (cur_active)
    );

    assign cnt_reset    = fn.crst;
    assign soft_pd      = fn.spd;
    assign mux_sel      = fn.mux;
    assign pd_polarity  = fn.pol;
    assign cp_hiz       = fn.hiz;
    assign fl_enable    = fn.fl_en;
    assign fl_timed     = fn.timed;
    assign tmo_code     = fn.tc;
    assign cur_main     = fn.cur_m;
    assign cur_boost    = fn.cur_b;
    assign pre_sel      = fn.pre;
    assign powered_down = pd;
endmodule

// File: tb/synth_prog_front_test.sv
module synth_prog_front_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, chip_en = 1'b1, pfd_tick = 1'b0;
    logic [13:0] ref_div;
    logic [5:0]  a_div;
    logic [12:0] b_div;
    logic gain, cnt_reset, soft_pd, pd_polarity, cp_hiz, fl_enable, fl_timed, powered_down;
    logic [2:0] mux_sel, cur_main, cur_boost, cur_active;
    logic [3:0] tmo_code;
    logic [1:0] pre_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    synth_prog_front uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .chip_en(chip_en), .pfd_tick(pfd_tick),
        .ref_div(ref_div), .a_div(a_div), .b_div(b_div), .gain(gain),
        .cnt_reset(cnt_reset), .soft_pd(soft_pd), .mux_sel(mux_sel),
        .pd_polarity(pd_polarity), .cp_hiz(cp_hiz), .fl_enable(fl_enable),
        .fl_timed(fl_timed), .tmo_code(tmo_code), .cur_main(cur_main),
        .cur_boost(cur_boost), .pre_sel(pre_sel), .cur_active(cur_active),
        .powered_down(powered_down)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
            wait_n(3);
            ser_clk = 1'b1;
            wait_n(3);
        end
        ser_clk = 1'b0;
        wait_n(3);
        ser_le = 1'b1;
        wait_n(8);
        ser_le = 1'b0;
        wait_n(4);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pfd_tick = 1'b1;
            @(negedge clk); pfd_tick = 1'b0;
            wait_n(1);
        end
    endtask

    function automatic logic [23:0] w_ref(input logic [13:0] r);
        return {8'h00, r, 2'b00};
    endfunction
    function automatic logic [23:0] w_div(input logic g, input logic [12:0] b, input logic [5:0] a);
        return {2'b00, g, b, a, 2'b01};
    endfunction
    function automatic logic [23:0] w_fn(input logic [1:0] pre, input logic [2:0] cb, input logic [2:0] cm,
                                         input logic [3:0] tc, input logic tm, input logic en,
                                         input logic hz, input logic pol, input logic [2:0] mx,
                                         input logic spd, input logic cr);
        return {pre, 1'b0, cb, cm, tc, tm, en, hz, pol, mx, spd, cr, 2'b10};
    endfunction

    task automatic t_reset;
        chk(ref_div == 0 && a_div == 0 && b_div == 0, "R4 reset dividers zero", ref_div, 0);
        chk(gain == 0 && cur_active == 0, "R7 reset gain/current zero", gain, 0);
        chk(powered_down == 0, "R10 reset not powered down", powered_down, 0);
    endtask

    task automatic t_ref;
        send(w_ref(14'h2A5C));
        chk(ref_div == 14'h2A5C, "R1 R4 reference pattern", ref_div, 14'h2A5C);
        send(w_ref(14'd1));
        chk(ref_div == 14'd1, "R4 reference minimum", ref_div, 1);
        send(w_ref(14'h3FFF));
        chk(ref_div == 14'h3FFF, "R4 reference maximum", ref_div, 16383);
    endtask

    task automatic t_div;
        send(w_div(1'b0, 13'h1ACB, 6'h25));
        chk(a_div == 6'h25, "R5 A field", a_div, 6'h25);
        chk(b_div == 13'h1ACB, "R5 B field", b_div, 13'h1ACB);
        chk(ref_div == 14'h3FFF, "R2 divider load leaves reference", ref_div, 16383);
    endtask

    task automatic t_func;
        send(w_fn(2'b10, 3'd6, 3'd1, 4'hB, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1));
        chk(pre_sel == 2 && cur_boost == 6 && cur_main == 1, "R6 prescaler/currents", {pre_sel, cur_boost, cur_main}, {2'd2, 3'd6, 3'd1});
        chk(tmo_code == 4'hB && !fl_timed && !fl_enable, "R6 timeout/mode", tmo_code, 11);
        chk(cp_hiz && pd_polarity && mux_sel == 5 && !soft_pd && cnt_reset, "R6 low fields",
            {cp_hiz, pd_polarity, mux_sel, soft_pd, cnt_reset}, {1'b1, 1'b1, 3'd5, 1'b0, 1'b1});
        chk(a_div == 6'h25 && ref_div == 14'h3FFF, "R2 function load leaves others", a_div, 6'h25);
    endtask

    task automatic t_code3;
        send(24'hFFFFFF);
        chk(ref_div == 14'h3FFF && a_div == 6'h25 && b_div == 13'h1ACB, "R3 code 11 dividers unchanged", b_div, 13'h1ACB);
        chk(pre_sel == 2 && cur_main == 1 && mux_sel == 5 && cnt_reset, "R3 code 11 function unchanged", mux_sel, 5);
        chk(gain == 0, "R3 code 11 gain unchanged", gain, 0);
    endtask

    task automatic t_disabled;
        send(w_fn(2'b00, 3'd5, 3'd2, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0));
        chk(cur_active == 2, "R7 disabled gain 0 uses main", cur_active, 2);
        send(w_div(1'b1, 13'd100, 6'd7));
        tick(10);
        chk(gain == 1 && cur_active == 5, "R7 disabled gain 1 permanent", cur_active, 5);
        send(w_div(1'b0, 13'd100, 6'd7));
        chk(cur_active == 2, "R7 disabled back to main", cur_active, 2);
    endtask

    task automatic t_mode1;
        send(w_fn(2'b00, 3'd5, 3'd2, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0));
        send(w_div(1'b1, 13'd100, 6'd7));
        tick(20);
        chk(gain == 1 && cur_active == 5, "R8 untimed holds boost", cur_active, 5);
        send(w_div(1'b0, 13'd100, 6'd7));
        chk(gain == 0 && cur_active == 2, "R8 untimed exit by write", cur_active, 2);
    endtask

    task automatic t_mode2(input logic [3:0] tc);
        int len = 3 + 4 * tc;
        send(w_fn(2'b00, 3'd5, 3'd2, tc, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0));
        send(w_div(1'b1, 13'd300, 6'd9));
        chk(cur_active == 5, "R9 timed start boost", cur_active, 5);
        tick(len - 1);
        chk(gain == 1, "R9 gain kept one tick before timeout", gain, 1);
        tick(1);
        chk(gain == 0 && cur_active == 2, "R9 gain cleared at timeout", gain, 0);
        chk(a_div == 9 && b_div == 300, "R9 dividers kept after expiry", b_div, 300);
    endtask

    task automatic t_restart;
        send(w_fn(2'b00, 3'd5, 3'd2, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0));
        send(w_div(1'b1, 13'd300, 6'd9));
        tick(5);
        send(w_div(1'b1, 13'd300, 6'd9));
        tick(6);
        chk(gain == 1, "R9 rewrite restarts timeout", gain, 1);
        tick(1);
        chk(gain == 0, "R9 restarted timeout ends", gain, 0);
    endtask

    task automatic t_power;
        chip_en = 1'b0;
        wait_n(5);
        chk(powered_down == 1, "R10 chip enable low powers down", powered_down, 1);
        send(w_ref(14'd777));
        chk(ref_div == 777, "R10 load accepted in power-down", ref_div, 777);
        chip_en = 1'b1;
        wait_n(5);
        chk(powered_down == 0, "R10 chip enable high resumes", powered_down, 0);
        send(w_fn(2'b00, 3'd5, 3'd2, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0));
        chk(powered_down == 1, "R10 software power-down", powered_down, 1);
        send(w_fn(2'b00, 3'd5, 3'd2, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0));
        chk(powered_down == 0, "R10 software power-down off", powered_down, 0);
    endtask

    task automatic t_pd_timer;
        send(w_div(1'b1, 13'd300, 6'd9));
        tick(3);
        chip_en = 1'b0;
        wait_n(5);
        tick(10);
        chk(gain == 1, "R11 ticks ignored in power-down", gain, 1);
        chip_en = 1'b1;
        wait_n(5);
        tick(6);
        chk(gain == 1, "R11 full count after power-down", gain, 1);
        tick(1);
        chk(gain == 0, "R11 expiry after reload", gain, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            done = 1;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        t_reset;
        t_ref;
        t_div;
        t_func;
        t_code3;
        t_disabled;
        t_mode1;
        t_mode2(4'd0);
        t_mode2(4'd15);
        t_restart;
        t_power;
        t_pd_timer;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule